// File: doc/BRIEF.md
# USB Device Control and Event Register Block

This block is the control and status core of a low-speed USB peripheral. It sits on an 8-bit register bus and decodes a 16-entry window at addresses 10h to 1Fh. Address 10h is the device control register. Address 11h is the event flag register. Every other address in the window is forwarded unchanged to a downstream bus port, which serves the FIFO, key-scan and mouse-port registers.

The control register holds four things:
- a stall enable for each of endpoints 0 to 3;
- a bit that drives the bus into the K state to wake the host, and a bit that blocks that remote wakeup;
- a power-down bit that stops the oscillator.

Firmware sets power-down after it sees suspend. Hardware clears power-down when it sees a wake condition on the synchronized line, sense or port-pin inputs. The event register collects status pulses from the serial engine into sticky flags, which firmware clears by writing 1 to them.

Top module: `usb_devctl_regs`

## Requirements
- R1: After reset, the control register reads 00h and the event register reads 00h. `stall_o`, `k_drive_o` and `clk_stop_o` are all 0.
- R2: A write to 10h takes effect at the next rising edge. Control layout:
  - bits 7..4 are the stall enables for endpoints 3..0, so `stall_o[i]` is bit 4+i;
  - bit 3 is wake drive, bit 2 is wakeup disable, bit 1 is power-down;
  - bit 0 always reads 0.
- R3: `k_drive_o` is 1 exactly when the wake-drive bit is 1 and the wakeup-disable bit is 0.
- R4: `clk_stop_o` equals the power-down bit.
- R5: While power-down is 1, a change of D+ or D- from the value held when power-down was entered clears power-down. The clear happens at the third rising edge after the pin change, and no earlier. The other control bits are kept.
- R6: While power-down is 1, any `sense_i` bit low or `port_pin_i` low clears power-down with the same three-edge latency.
- R7: A wake condition clears power-down even in a cycle where firmware writes 1 to power-down. The other bits of that write still take effect.
- R8: A one-cycle pulse on `evt_set_i[n]` sets event bit n at the next edge. Bit order, from 7 down to 0: wakeup, resume, suspend, EP3 transmit, EP2 transmit, EP1 transmit, EP0 transmit, EP0 receive.
- R9: Writing 11h clears each event bit written as 1 and leaves each bit written as 0 unchanged.
- R10: When a set pulse and a write of 1 hit the same event bit in the same cycle, the bit ends at 1.
- R11: Accesses to 12h to 1Fh are forwarded in the same cycle:
  - `down_wr_o` or `down_rd_o` is asserted;
  - `down_addr_o` is the low address nibble and `down_wdata_o` is the write data;
  - `bus_rdata_o` returns `down_rdata_i`.
  Accesses to 10h, to 11h or outside 10h to 1Fh assert neither strobe, and reads outside the window return 0.
- R12: Writes to addresses other than 10h and 11h change neither the control register nor the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| down_wr_o | output | 1 | Forwarded write strobe |
| down_rd_o | output | 1 | Forwarded read strobe |
| down_addr_o | output | 4 | Forwarded address offset |
| down_wdata_o | output | 8 | Forwarded write data |
| down_rdata_i | input | 8 | Read data from the downstream port |
| evt_set_i | input | 8 | Event set pulses, one per flag |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| sense_i | input | 8 | Key sense inputs, active-low wake |
| port_pin_i | input | 1 | Port wake pin, active-low wake |
| stall_o | output | 4 | Per-endpoint stall enables |
| k_drive_o | output | 1 | Drive K state for remote wakeup |
| clk_stop_o | output | 1 | Stop the oscillator |

## Verification
Results fall due at three different times:
- Reads and forwarded strobes are combinational, so the bench samples them one nanosecond after it drives the access, inside the same low clock phase.
- Register writes and event pulses land at the next rising edge, so the bench checks them at the falling edge that follows.
- A wake pin change passes two synchronizer flops before the detector sees it, so power-down clears at the third rising edge. The bench checks that power-down is still set after two edges and cleared after the third. The write-versus-wake collision is placed exactly in that third cycle.

// File: rtl/usb_devctl_pkg.sv
package usb_devctl_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int OFS_W     = 4;
  localparam int NUM_EP    = 4;
  localparam int SENSE_W   = 8;
  localparam int EVT_W     = 8;
  localparam int SYNC_STG  = 2;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h10;
  localparam logic [ADDR_W-1:0] EVT_ADDR  = 8'h11;
  localparam logic [ADDR_W-OFS_W-1:0] WIN_PAGE = 4'h1;

  localparam int STALL_LSB = 4;
  localparam int WAKE_BIT  = 3;
  localparam int WKDIS_BIT = 2;
  localparam int PWRDN_BIT = 1;

  typedef struct packed {
    logic [NUM_EP-1:0] stall;
    logic              wake;
    logic              wkdis;
    logic              pwrdn;
  } ctrl_t;
endpackage

// File: rtl/devctl_sync.sv
module devctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/devctl_wake_det.sv
module devctl_wake_det #(
  parameter int SENSE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrdn_i,
  input  logic [1:0]         line_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               port_i,
  output logic               wake_o
);
  logic [1:0] ref_q;

  // track lines while awake; freeze on power-down entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_q <= '0;
    else if (!pwrdn_i) ref_q <= line_i;
  end

  assign wake_o = pwrdn_i & ((line_i != ref_q) | ~(&sense_i) | ~port_i);

  assert_ref_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrdn_i && $past(pwrdn_i)) |-> $stable(ref_q));
endmodule

// File: rtl/devctl_ctrl_reg.sv
module devctl_ctrl_reg
  import usb_devctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_clr_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;
  logic  unused_bit0;

  assign unused_bit0 = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.stall <= wdata_i[STALL_LSB +: NUM_EP];
      ctrl_q.wake  <= wdata_i[WAKE_BIT];
      ctrl_q.wkdis <= wdata_i[WKDIS_BIT];
      ctrl_q.pwrdn <= wdata_i[PWRDN_BIT] & ~hw_clr_i;  // hardware clear wins
    end else if (hw_clr_i) begin
      ctrl_q.pwrdn <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  assert_wake_clears_pwrdn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr_i |=> !ctrl_q.pwrdn);
  assert_write_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctrl_q.stall == $past(wdata_i[STALL_LSB +: NUM_EP]));
  assert_pwrdn_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !hw_clr_i) |=> $stable(ctrl_q.pwrdn));
endmodule

// File: rtl/devctl_event_reg.sv
module devctl_event_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/usb_devctl_regs.sv
module usb_devctl_regs
  import usb_devctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               down_wr_o,
  output logic               down_rd_o,
  output logic [OFS_W-1:0]   down_addr_o,
  output logic [DATA_W-1:0]  down_wdata_o,
  input  logic [DATA_W-1:0]  down_rdata_i,
  input  logic [EVT_W-1:0]   evt_set_i,
  input  logic               dp_i,
  input  logic               dm_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               port_pin_i,
  output logic [NUM_EP-1:0]  stall_o,
  output logic               k_drive_o,
  output logic               clk_stop_o
);
  localparam int SYNC_W = 2 + SENSE_W + 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b00, {(SENSE_W+1){1'b1}}};

  logic in_win, sel_ctrl, sel_evt, sel_down;
  logic [SYNC_W-1:0] sync_d, sync_q;
  logic wake;
  ctrl_t ctrl;
  logic [EVT_W-1:0] evt_flags, evt_clr;
  logic [DATA_W-1:0] ctrl_rd;

  assign in_win   = bus_addr_i[ADDR_W-1:OFS_W] == WIN_PAGE;
  assign sel_ctrl = bus_addr_i == CTRL_ADDR;
  assign sel_evt  = bus_addr_i == EVT_ADDR;
  assign sel_down = in_win & ~sel_ctrl & ~sel_evt;

  assign down_wr_o    = bus_wr_i & sel_down;
  assign down_rd_o    = bus_rd_i & sel_down;
  assign down_addr_o  = bus_addr_i[OFS_W-1:0];
  assign down_wdata_o = bus_wdata_i;

  assign sync_d = {dp_i, dm_i, sense_i, port_pin_i};

  devctl_sync #(.W(SYNC_W), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(sync_d), .q_o(sync_q)
  );

  devctl_wake_det #(.SENSE_W(SENSE_W)) u_wake (
    .clk_i, .rst_ni,
    .pwrdn_i (ctrl.pwrdn),
    .line_i  (sync_q[SYNC_W-1 -: 2]),
    .sense_i (sync_q[SENSE_W:1]),
    .port_i  (sync_q[0]),
    .wake_o  (wake)
  );

  devctl_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .wr_i     (bus_wr_i & sel_ctrl),
    .wdata_i  (bus_wdata_i),
    .hw_clr_i (wake),
    .ctrl_o   (ctrl)
  );

  assign evt_clr = (bus_wr_i && sel_evt) ? bus_wdata_i : '0;

  devctl_event_reg #(.N(EVT_W)) u_evt (
    .clk_i, .rst_ni,
    .set_i   (evt_set_i),
    .clr_i   (evt_clr),
    .flags_o (evt_flags)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[STALL_LSB +: NUM_EP] = ctrl.stall;
    ctrl_rd[WAKE_BIT]  = ctrl.wake;
    ctrl_rd[WKDIS_BIT] = ctrl.wkdis;
    ctrl_rd[PWRDN_BIT] = ctrl.pwrdn;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      if (sel_ctrl)      bus_rdata_o = ctrl_rd;
      else if (sel_evt)  bus_rdata_o = evt_flags;
      else if (sel_down) bus_rdata_o = down_rdata_i;
    end
  end

  assign stall_o    = ctrl.stall;
  assign k_drive_o  = ctrl.wake & ~ctrl.wkdis;
  assign clk_stop_o = ctrl.pwrdn;

  assert_no_fwd_local_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i[ADDR_W-1:OFS_W] != WIN_PAGE || bus_addr_i[OFS_W-1:1] == '0)
      |-> !(down_wr_o || down_rd_o));
  assert_kdrive_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && sel_ctrl && bus_wdata_i[WKDIS_BIT]) |=> !k_drive_o);
endmodule

// File: tb/usb_devctl_regs_tb.sv
module usb_devctl_regs_tb;
  logic clk = 0, rst_ni = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic down_wr, down_rd;
  logic [3:0] down_addr;
  logic [7:0] down_wdata, down_rdata = 0;
  logic [7:0] evt_set = 0;
  logic dp = 0, dm = 0;
  logic [7:0] sense = 8'hFF;
  logic port_pin = 1;
  logic [3:0] stall;
  logic k_drive, clk_stop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_devctl_regs u_dut (
    .clk_i(clk), .rst_ni, .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .down_wr_o(down_wr), .down_rd_o(down_rd), .down_addr_o(down_addr),
    .down_wdata_o(down_wdata), .down_rdata_i(down_rdata),
    .evt_set_i(evt_set), .dp_i(dp), .dm_i(dm), .sense_i(sense),
    .port_pin_i(port_pin), .stall_o(stall), .k_drive_o(k_drive),
    .clk_stop_o(clk_stop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    #1 bus_rd = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 stall", stall, 0);
    chk("R1 k_drive", k_drive, 0);
    chk("R1 clk_stop", clk_stop, 0);
    rd(8'h10, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h11, v); chk("R1 evt", v, 8'h00);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] v;
    wr(8'h10, 8'hF1);
    rd(8'h10, v); chk("R2 bit0 reads 0", v, 8'hF0);
    chk("R2 stall all", stall, 4'hF);
    wr(8'h10, 8'hA0);
    chk("R2 stall order", stall, 4'b1010);
    wr(8'h10, 8'h00);
  endtask

  task automatic t_kdrive();
    wr(8'h10, 8'h08); chk("R3 k on", k_drive, 1);
    wr(8'h10, 8'h0C); chk("R3 k blocked", k_drive, 0);
    wr(8'h10, 8'h04); chk("R3 k off", k_drive, 0);
    wr(8'h10, 8'h00);
  endtask

  task automatic t_dp_wake();
    logic [7:0] v;
    wr(8'h10, 8'h32);
    chk("R4 clk_stop set", clk_stop, 1);
    settle();
    chk("R4 clk_stop held", clk_stop, 1);
    @(negedge clk); dp = ~dp;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R5 not before third edge", clk_stop, 1);
    @(posedge clk);
    @(negedge clk); chk("R5 cleared at third edge", clk_stop, 0);
    rd(8'h10, v); chk("R5 other bits kept", v, 8'h30);
    wr(8'h10, 8'h02); settle();
    @(negedge clk); dm = ~dm;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R5 dm toggle", clk_stop, 0);
    wr(8'h10, 8'h00); settle();
  endtask

  task automatic t_sense_port();
    wr(8'h10, 8'h02);
    @(negedge clk); sense[5] = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); chk("R6 sense not yet", clk_stop, 1);
    @(posedge clk);
    @(negedge clk); chk("R6 sense wake", clk_stop, 0);
    sense = 8'hFF; settle();
    wr(8'h10, 8'h02);
    @(negedge clk); port_pin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R6 port wake", clk_stop, 0);
    port_pin = 1; settle();
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(8'h10, 8'h02);
    @(negedge clk); port_pin = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h10; bus_wdata = 8'h92;
    @(negedge clk); bus_wr = 0;
    chk("R7 clear beats write", clk_stop, 0);
    chk("R7 stall from write", stall, 4'b1001);
    rd(8'h10, v); chk("R7 readback", v, 8'h90);
    port_pin = 1; wr(8'h10, 8'h00); settle();
  endtask

  task automatic t_events();
    logic [7:0] v;
    @(negedge clk); evt_set = 8'h81;
    @(negedge clk); evt_set = 0;
    rd(8'h11, v); chk("R8 set 81", v, 8'h81);
    @(negedge clk); evt_set = 8'h24;
    @(negedge clk); evt_set = 0;
    rd(8'h11, v); chk("R8 set 24", v, 8'hA5);
    wr(8'h11, 8'h05); rd(8'h11, v); chk("R9 clear 05", v, 8'hA0);
    wr(8'h11, 8'h00); rd(8'h11, v); chk("R9 zero no effect", v, 8'hA0);
    wr(8'h11, 8'hFF); rd(8'h11, v); chk("R9 clear all", v, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    @(negedge clk);
    evt_set = 8'h08; bus_wr = 1; bus_addr = 8'h11; bus_wdata = 8'h08;
    @(negedge clk); evt_set = 0; bus_wr = 0;
    rd(8'h11, v); chk("R10 set wins", v, 8'h08);
    wr(8'h11, 8'h08); rd(8'h11, v); chk("R10 later clear", v, 8'h00);
  endtask

  task automatic t_forward();
    logic [7:0] v;
    @(negedge clk); bus_wr = 1; bus_addr = 8'h15; bus_wdata = 8'h5A;
    #1 chk("R11 down_wr", down_wr, 1);
    chk("R11 down_addr", down_addr, 4'h5);
    chk("R11 down_wdata", down_wdata, 8'h5A);
    @(negedge clk); bus_wr = 1; bus_addr = 8'h10; bus_wdata = 8'h00;
    #1 chk("R11 local no fwd", down_wr, 0);
    @(negedge clk); bus_wr = 0;
    down_rdata = 8'hC3;
    @(negedge clk); bus_rd = 1; bus_addr = 8'h1F;
    #1 chk("R11 down_rd", down_rd, 1);
    chk("R11 rd addr", down_addr, 4'hF);
    chk("R11 rdata pass", bus_rdata, 8'hC3);
    #1 bus_rd = 0;
    @(negedge clk); bus_rd = 1; bus_addr = 8'h25;
    #1 chk("R11 outside rd", down_rd, 0);
    chk("R11 outside zero", bus_rdata, 8'h00);
    #1 bus_rd = 0;
    down_rdata = 0;
  endtask

  task automatic t_other_writes();
    logic [7:0] v;
    wr(8'h10, 8'h50);
    @(negedge clk); evt_set = 8'h11;
    @(negedge clk); evt_set = 0;
    wr(8'h20, 8'hFF); wr(8'h00, 8'hFF); wr(8'h12, 8'hFF); wr(8'h01, 8'hFF);
    rd(8'h10, v); chk("R12 ctrl kept", v, 8'h50);
    rd(8'h11, v); chk("R12 evt kept", v, 8'h11);
    wr(8'h11, 8'hFF); wr(8'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    settle();
    t_reset();
    t_ctrl_rw();
    t_kdrive();
    t_dp_wake();
    t_sense_port();
    t_collide();
    t_events();
    t_set_wins();
    t_forward();
    t_other_writes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule